// File: doc/BRIEF.md
# UART Interrupt Enable and Identification

This block merges the interrupt causes of a classic single-channel UART into one active-high interrupt line and an 8-bit identification byte that the CPU reads. There are four cause groups: receive-side line errors, newly arrived receive data, an empty transmit holding register, and modem-control input changes. Each group has its own enable bit in an 8-bit enable register. The CPU writes and reads that register through the block's register port.

Each group has a pending flag. The line-error and modem groups each OR four event inputs. The flag latches whenever its events arrive, whether or not the group is enabled. Only the interrupt line and the identification byte are masked. The identification byte shows a two-bit code for the most urgent pending enabled group. Each pending flag is cleared by its own acknowledge strobe, which stands for the CPU's read of the status register or receive buffer that lives outside this block. The transmit-empty group also clears on a read of the identification byte that reports it.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, `irq_o` is low and `iir_o` reads 0x01.
- R2: Writing the enable register stores bits 3..0: bit 0 enables received data, bit 1 enables transmit-empty, bit 2 enables line errors and bit 3 enables modem changes. Bits 7..4 always read back as 0.
- R3: `irq_o` is high exactly when at least one enabled group is pending. `iir_o[0]` is its inverse (0 means pending).
- R4: `iir_o[2:1]` carries the code of the highest-priority pending enabled group: line errors 11 (highest), received data 10, transmit-empty 01, modem changes 00 (lowest). `iir_o[7:3]` reads 0, and `iir_o[2:1]` reads 00 when nothing is pending.
- R5: A pulse on any bit of `line_err_i` sets the line-error flag. `lsr_rd_i` clears it.
- R6: A pulse on any bit of `modem_delta_i` sets the modem flag. `msr_rd_i` clears it.
- R7: `rx_load_i` sets the received-data flag. `rx_buf_rd_i` clears it.
- R8: Events that arrive while their group is disabled are still latched. They appear on `irq_o` and `iir_o` once the group is enabled.
- R9: When a set event and its clear strobe occur in the same cycle, the flag ends up set.
- R10: The transmit-empty flag sets on a rising edge of `thr_empty_i`, or when its enable bit is written from 0 to 1 while `thr_empty_i` is high. It clears on `thr_wr_i` or on `id_rd_i` while `iir_o` reports code 01.
- R11: `id_rd_i` while another group is reported leaves the transmit-empty flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 8 | Write data for the enable register |
| en_rdata_o | output | 8 | Enable register read-back |
| id_rd_i | input | 1 | Identification register read strobe |
| iir_o | output | 8 | Identification register value |
| irq_o | output | 1 | Active-high interrupt request |
| rx_load_i | input | 1 | Pulse: a received character entered the buffer |
| rx_buf_rd_i | input | 1 | Pulse: CPU read the receive buffer |
| line_err_i | input | 4 | Pulses: overrun, parity, framing, break |
| lsr_rd_i | input | 1 | Pulse: CPU read the line status register |
| modem_delta_i | input | 4 | Pulses: modem input change events |
| msr_rd_i | input | 1 | Pulse: CPU read the modem status register |
| thr_empty_i | input | 1 | Level: transmit holding register is empty |
| thr_wr_i | input | 1 | Pulse: CPU wrote the transmit holding register |

## Verification
Two things can land in the same cycle: a group's new event and the CPU acknowledge that clears it. The bench drives the event pulse and the matching clear strobe on the same edge, for both the modem and the line-error groups. After that edge the code must still be reported, because a lost event would be a silent hang. A second collision is an identification read that happens while line errors outrank a pending transmit-empty. The bench checks that the lower group is still reported after the line errors are acknowledged.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NSRC = 4;
  localparam int unsigned IDW  = 2;

  // group code doubles as priority rank (higher value wins)
  typedef enum logic [IDW-1:0] {
    SRC_MODEM  = 2'b00,
    SRC_THRE   = 2'b01,
    SRC_RXDATA = 2'b10,
    SRC_LINE   = 2'b11
  } src_id_e;

  // positions of the enable bits in the software-visible register
  localparam int unsigned EN_RXDATA = 0;
  localparam int unsigned EN_THRE   = 1;
  localparam int unsigned EN_LINE   = 2;
  localparam int unsigned EN_MODEM  = 3;
endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_d;

  // a new event outranks an acknowledge in the same cycle
  always_comb begin
    pend_d = pend_o;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_d;
  end
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk,
  input  logic rst_n,
  input  logic empty_i,
  input  logic en_rise_i,
  input  logic hold_wr_i,
  input  logic ack_i,
  output logic pend_o
);
  logic empty_q;
  logic empty_d;
  logic arm;
  logic disarm;

  // holding register is empty out of reset, so no edge is seen then
  assign empty_d = empty_i;
  assign arm     = (empty_i & ~empty_q) | (en_rise_i & empty_i);
  assign disarm  = hold_wr_i | ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b1;
    else        empty_q <= empty_d;
  end

  uart_irq_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (arm),
    .clr_i  (disarm),
    .pend_o (pend_o)
  );
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = NSRC,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] id_o
);
  // highest index wins: ascending scan, last hit kept
  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        id_o  = W'(i);
      end
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned N_LINE_ERR    = 4,
  parameter int unsigned N_MODEM_DELTA = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_wr_i,
  input  logic [DATA_W-1:0]        en_wdata_i,
  output logic [DATA_W-1:0]        en_rdata_o,
  input  logic                     id_rd_i,
  output logic [DATA_W-1:0]        iir_o,
  output logic                     irq_o,
  input  logic                     rx_load_i,
  input  logic                     rx_buf_rd_i,
  input  logic [N_LINE_ERR-1:0]    line_err_i,
  input  logic                     lsr_rd_i,
  input  logic [N_MODEM_DELTA-1:0] modem_delta_i,
  input  logic                     msr_rd_i,
  input  logic                     thr_empty_i,
  input  logic                     thr_wr_i
);
  localparam int unsigned EN_W  = NSRC;
  localparam int unsigned PAD_W = DATA_W - 1 - IDW;

  logic [EN_W-1:0] en_q;
  logic [EN_W-1:0] en_d;
  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] clr_v;
  logic [NSRC-1:0] pend_v;
  logic [NSRC-1:0] mask_v;
  logic            any_pend;
  logic [IDW-1:0]  top_id;
  logic            en_thre_rise;
  logic            thre_ack;

  // enable register: next state, then storage
  always_comb begin
    en_d = en_q;
    if (en_wr_i) en_d = en_wdata_i[EN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_rdata_o   = {{(DATA_W-EN_W){1'b0}}, en_q};
  assign en_thre_rise = en_wr_i & en_wdata_i[EN_THRE] & ~en_q[EN_THRE];
  assign thre_ack     = id_rd_i & any_pend & (top_id == SRC_THRE);

  // set and clear strobes per group, indexed by group code
  always_comb begin
    set_v             = '0;
    clr_v             = '0;
    set_v[SRC_LINE]   = |line_err_i;
    clr_v[SRC_LINE]   = lsr_rd_i;
    set_v[SRC_RXDATA] = rx_load_i;
    clr_v[SRC_RXDATA] = rx_buf_rd_i;
    set_v[SRC_MODEM]  = |modem_delta_i;
    clr_v[SRC_MODEM]  = msr_rd_i;
  end

  // enable bit order differs from code order; remap into code order
  always_comb begin
    mask_v             = '0;
    mask_v[SRC_LINE]   = en_q[EN_LINE];
    mask_v[SRC_RXDATA] = en_q[EN_RXDATA];
    mask_v[SRC_THRE]   = en_q[EN_THRE];
    mask_v[SRC_MODEM]  = en_q[EN_MODEM];
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == SRC_THRE) begin : g_thre
      uart_irq_thre u_thre (
        .clk       (clk),
        .rst_n     (rst_n),
        .empty_i   (thr_empty_i),
        .en_rise_i (en_thre_rise),
        .hold_wr_i (thr_wr_i),
        .ack_i     (thre_ack),
        .pend_o    (pend_v[g])
      );
    end else begin : g_evt
      uart_irq_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v[g]),
        .clr_i  (clr_v[g]),
        .pend_o (pend_v[g])
      );
    end
  end

  uart_irq_prio #(.N(NSRC)) u_prio (
    .req_i (pend_v & mask_v),
    .any_o (any_pend),
    .id_o  (top_id)
  );

  assign irq_o = any_pend;
  assign iir_o = {{PAD_W{1'b0}}, top_id, ~any_pend};
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned N_LINE_ERR = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en_wr_i,
  input logic [DATA_W-1:0]     en_rdata_o,
  input logic [DATA_W-1:0]     iir_o,
  input logic                  irq_o,
  input logic [N_LINE_ERR-1:0] line_err_i,
  input logic                  lsr_rd_i,
  input logic                  thr_wr_i,
  input logic                  thr_empty_i
);
  // R2
  en_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rdata_o[DATA_W-1:4] == '0);

  // R3
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|en_rdata_o[3:0]));

  // R4
  iir_idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iir_o[0] |-> (iir_o[DATA_W-1:1] == '0));

  // R5
  line_err_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|line_err_i) && en_rdata_o[2] && !en_wr_i) |=> (iir_o[2:0] == 3'b110));

  // R5
  line_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd_i && !(|line_err_i)) |=> (iir_o[2:0] != 3'b110));

  // R10
  thre_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_i && !thr_empty_i) |=> (iir_o[2:0] != 3'b010));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.DATA_W(DATA_W), .N_LINE_ERR(N_LINE_ERR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_wr_i     (en_wr_i),
  .en_rdata_o  (en_rdata_o),
  .iir_o       (iir_o),
  .irq_o       (irq_o),
  .line_err_i  (line_err_i),
  .lsr_rd_i    (lsr_rd_i),
  .thr_wr_i    (thr_wr_i),
  .thr_empty_i (thr_empty_i)
);

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_wr_i;
  logic [7:0] en_wdata_i;
  logic [7:0] en_rdata_o;
  logic       id_rd_i;
  logic [7:0] iir_o;
  logic       irq_o;
  logic       rx_load_i, rx_buf_rd_i;
  logic [3:0] line_err_i;
  logic       lsr_rd_i;
  logic [3:0] modem_delta_i;
  logic       msr_rd_i;
  logic       thr_empty_i, thr_wr_i;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .en_rdata_o(en_rdata_o), .id_rd_i(id_rd_i), .iir_o(iir_o), .irq_o(irq_o),
    .rx_load_i(rx_load_i), .rx_buf_rd_i(rx_buf_rd_i), .line_err_i(line_err_i),
    .lsr_rd_i(lsr_rd_i), .modem_delta_i(modem_delta_i), .msr_rd_i(msr_rd_i),
    .thr_empty_i(thr_empty_i), .thr_wr_i(thr_wr_i)
  );

  // set/clr bits: [2] line errors, [1] received data, [0] modem
  typedef struct packed {
    logic [3:0] en;
    logic [2:0] set;
    logic [2:0] clr;
    logic [7:0] iir;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{4'h0, 3'b111, 3'b000, 8'h01},  // R8 latched while masked
    '{4'hF, 3'b000, 3'b000, 8'h06},  // R4 line errors on top
    '{4'hF, 3'b000, 3'b100, 8'h04},  // R5 ack, received data next
    '{4'h8, 3'b000, 3'b000, 8'h00},  // R2 modem only
    '{4'h1, 3'b000, 3'b000, 8'h04},  // R2 received data only
    '{4'h1, 3'b000, 3'b010, 8'h01},  // R7 ack, modem still masked
    '{4'hF, 3'b000, 3'b000, 8'h00},  // R8 modem surfaces
    '{4'hF, 3'b001, 3'b001, 8'h00},  // R9 set beats clear (modem)
    '{4'hF, 3'b000, 3'b001, 8'h01},  // R6 ack
    '{4'hF, 3'b100, 3'b100, 8'h06},  // R9 set beats clear (line)
    '{4'hF, 3'b000, 3'b100, 8'h01}   // R5 ack
  };

  task automatic chk_iir(input string req, input logic [7:0] exp);
    n_chk++;
    if (iir_o !== exp || irq_o !== ~exp[0]) begin
      n_fail++;
      $display("FAIL %s: iir=%02h irq=%b expected iir=%02h irq=%b",
               req, iir_o, irq_o, exp, ~exp[0]);
    end
  endtask

  task automatic chk_en(input string req, input logic [7:0] exp);
    n_chk++;
    if (en_rdata_o !== exp) begin
      n_fail++;
      $display("FAIL %s: en=%02h expected en=%02h", req, en_rdata_o, exp);
    end
  endtask

  task automatic idle_in();
    en_wr_i = 0; en_wdata_i = 0; id_rd_i = 0; rx_load_i = 0; rx_buf_rd_i = 0;
    line_err_i = 0; lsr_rd_i = 0; modem_delta_i = 0; msr_rd_i = 0; thr_wr_i = 0;
  endtask

  // inputs already driven after a falling edge; one rising edge, then sample
  task automatic tick();
    @(negedge clk);
    idle_in();
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_wr_i = 1; en_wdata_i = v; tick();
  endtask

  task automatic do_reset();
    rst_n = 0; idle_in();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    thr_empty_i = 0;
    do_reset();
    chk_iir("R1", 8'h01);
    chk_en("R1", 8'h00);

    wr_en(8'hFF); chk_en("R2", 8'h0F);
    wr_en(8'hA5); chk_en("R2", 8'h05);
    wr_en(8'h00); chk_iir("R3", 8'h01);

    foreach (VEC[i]) begin
      en_wr_i = 1; en_wdata_i = {4'h0, VEC[i].en};
      line_err_i    = VEC[i].set[2] ? 4'b0001 : 4'b0000;
      rx_load_i     = VEC[i].set[1];
      modem_delta_i = VEC[i].set[0] ? 4'b0100 : 4'b0000;
      lsr_rd_i      = VEC[i].clr[2];
      rx_buf_rd_i   = VEC[i].clr[1];
      msr_rd_i      = VEC[i].clr[0];
      tick();
      chk_iir($sformatf("R4 vec%0d", i), VEC[i].iir);
    end

    // R5 and R6: every event bit counts
    for (int b = 0; b < 4; b++) begin
      line_err_i = 4'(1 << b); tick(); chk_iir("R5", 8'h06);
      lsr_rd_i = 1; tick(); chk_iir("R5", 8'h01);
      modem_delta_i = 4'(1 << b); tick(); chk_iir("R6", 8'h00);
      msr_rd_i = 1; tick(); chk_iir("R6", 8'h01);
    end

    // transmit-empty group
    wr_en(8'h00);
    thr_empty_i = 1; tick(); chk_iir("R10 masked", 8'h01);
    wr_en(8'h02);            chk_iir("R10", 8'h02);
    id_rd_i = 1; tick();     chk_iir("R10 id ack", 8'h01);
    wr_en(8'h02);            chk_iir("R10 no rearm", 8'h01);
    wr_en(8'h00);
    wr_en(8'h02);            chk_iir("R10 enable rearm", 8'h02);
    thr_wr_i = 1; thr_empty_i = 0; tick(); chk_iir("R10 write ack", 8'h01);
    thr_empty_i = 1; tick(); chk_iir("R10 empty edge", 8'h02);
    en_wr_i = 1; en_wdata_i = 8'h06; line_err_i = 4'b1000; tick();
    chk_iir("R4", 8'h06);
    id_rd_i = 1; tick();     chk_iir("R11", 8'h06);
    lsr_rd_i = 1; tick();    chk_iir("R11", 8'h02);

    // R7 received data over transmit-empty
    rx_load_i = 1; tick();   chk_iir("R7", 8'h02);
    wr_en(8'h07);            chk_iir("R7", 8'h04);

    // reset with groups pending
    thr_empty_i = 0;
    modem_delta_i = 4'b0010; line_err_i = 4'b0010; tick();
    do_reset();
    chk_iir("R1 after activity", 8'h01);
    chk_en("R1 after activity", 8'h00);
    wr_en(8'h0F);            chk_iir("R1 flags cleared", 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule